// File: doc/BRIEF.md
# Exception Return Sequencer

This unit runs the exit of an interrupt service routine on a processor core. When the handler finishes, the core raises a return request. The unit then looks at the highest pending exception and the highest stacked (active) exception and picks one of three exits.

- **Tail-chain:** go straight into the pending handler. No memory traffic is needed.
- **Stacked ISR:** unwind into the most recently stacked handler.
- **Thread:** go back to the interrupted thread-level program.

The two unwinding exits restore the saved eight-word frame from the stack. Each word goes to the register file, one word per cycle. The unit then moves the stack pointer past the frame and takes the new active exception number from the restored status word.

The memory port is a plain word read with a same-cycle response: `rd_data` and `rd_err` are valid in the cycle that `rd_req` is high. A single cycle-wide `done` pulse reports which exit was taken. A bus error during the unwind aborts the sequence and raises `fault` in place of `done`. The unit does not do instruction execution, exception entry, or prioritisation of the interrupt sources. It is given the winning pending and stacked levels.

Top module: `exc_return_seq`

## Requirements
- R1: When `pend_valid` is high and either `stk_valid` is low or `pend_prio` is numerically lower than `stk_prio`, the unit tail-chains.
  - `done` rises in the cycle after the accepted request, with `outcome` = 2 and `active_num` = `pend_num`.
  - No memory read and no stack pointer write are issued.
- R2: When no tail-chain applies and `stk_valid` is high, the unit unwinds the frame and reports `outcome` = 1 (stacked ISR).
- R3: When `pend_valid` and `stk_valid` are both low, the unit unwinds the frame and reports `outcome` = 0 (thread).
- R4: A numerically lower priority value outranks a higher one. Equal pending and stacked priorities never preempt: the result is `outcome` = 1.
- R5: An unwind issues eight reads, one per cycle, at ascending word addresses starting at the frame base.
  - Each word is written to the register file in the cycle it is read (`rf_we`, `rf_wdata` = `rd_data`).
  - The `rf_idx` values, in read order, are 0, 1, 2, 3, 12, 14, 15, 16. Index 16 denotes the status word.
- R6: A completed unwind raises `done` in the cycle after the last read, nine cycles after the request edge. In the same cycle it pulses `sp_wr_en` with `sp_wr_val` = frame base + 32.
- R7: After an unwind, `active_num` equals bits [8:0] of the restored status word (the eighth word). `cur_handler` is high exactly when `active_num` is non-zero.
- R8: The selected stack pointer is process when `ret_thread` = 1 and `ret_psp` = 1, and main otherwise.
  - The frame base is taken from `psp_in` when process is selected and from `msp_in` when main is selected.
  - The same selection appears on `sp_wr_sel` and on `sp_sel` (1 = process).
- R9: A return request that arrives while `busy` is high is ignored. The running unwind continues unchanged and no extra `done` follows.
- R10: A read with `rd_err` high stops the unwind.
  - `fault` pulses for one cycle in the next cycle.
  - `done` and `sp_wr_en` stay low, and `active_num` is unchanged.
- R11: After reset, `done`, `fault`, `busy`, `rd_req`, `rf_we`, `sp_wr_en` and `sp_sel` are 0, `outcome` is 0 and `active_num` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ret_req | input | 1 | Handler exit request |
| ret_thread | input | 1 | Exit frame targets thread mode |
| ret_psp | input | 1 | In thread mode, use the process stack pointer |
| pend_valid | input | 1 | A pending exception exists |
| pend_prio | input | PRIO_W | Priority of the highest pending exception (lower value is more urgent) |
| pend_num | input | NUM_W | Number of the highest pending exception |
| stk_valid | input | 1 | A stacked exception exists |
| stk_prio | input | PRIO_W | Priority of the highest stacked exception |
| msp_in | input | ADDR_W | Current main stack pointer |
| psp_in | input | ADDR_W | Current process stack pointer |
| rd_req | output | 1 | Memory read strobe |
| rd_addr | output | ADDR_W | Memory read word address (byte units) |
| rd_data | input | DATA_W | Read data, valid in the same cycle as `rd_req` |
| rd_err | input | 1 | Read error, valid in the same cycle as `rd_req` |
| rf_we | output | 1 | Register file write enable |
| rf_idx | output | IDX_W | Register file index (16 = status word) |
| rf_wdata | output | DATA_W | Register file write data |
| sp_wr_en | output | 1 | Stack pointer write-back pulse |
| sp_wr_sel | output | 1 | Stack pointer written (1 = process) |
| sp_wr_val | output | ADDR_W | New stack pointer value |
| busy | output | 1 | An unwind is in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | One-cycle read-error abort pulse |
| outcome | output | 2 | Exit taken: 0 thread, 1 stacked ISR, 2 tail-chain |
| active_num | output | NUM_W | Current active exception number |
| cur_handler | output | 1 | Core is in handler mode (`active_num` non-zero) |
| sp_sel | output | 1 | Current stack pointer selection (1 = process) |

## Verification
The hardest situations to reach from the ports are the ones that depend on timing inside a running unwind.

- **Request while busy:** a second exit request must arrive while an unwind is already in progress. The stimulus raises `ret_req` in the middle of the pop, with inputs that would tail-chain if accepted. It then checks that the eight-word sequence, the completion latency and the reported exit are unchanged, and that no further `done` follows.
- **Mid-frame read error:** the bench memory model arms an error on one chosen word address inside the frame. This checks that the register writes stop at that word and that the stack pointer and active number stay untouched.

The decision logic is covered by an exhaustive sweep over every combination of pending and stacked valid flags and 3-bit priority levels. The mode flags and stack pointer values rotate across the sweep.

// File: rtl/exr_pkg.sv
package exr_pkg;

   typedef enum logic [1:0] {
      EXR_THREAD  = 2'd0,
      EXR_STACKED = 2'd1,
      EXR_TAIL    = 2'd2
   } exr_outcome_e;

   // Register file index of the word held in each frame slot, in ascending
   // address order. Index 16 is the status word.
   function automatic logic [4:0] exr_slot_reg(input int slot);
      logic [4:0] r;
      case (slot)
         0:       r = 5'd0;
         1:       r = 5'd1;
         2:       r = 5'd2;
         3:       r = 5'd3;
         4:       r = 5'd12;
         5:       r = 5'd14;
         6:       r = 5'd15;
         default: r = 5'd16;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/exr_decide.sv
module exr_decide
   import exr_pkg::*;
#(
   parameter int PRIO_W = 3
) (
   input  logic              pend_valid,
   input  logic [PRIO_W-1:0] pend_prio,
   input  logic              stk_valid,
   input  logic [PRIO_W-1:0] stk_prio,
   output exr_outcome_e      path
);

   logic outranks;

   // Lower value wins; a tie is not a preemption.
   assign outranks = !stk_valid || (pend_prio < stk_prio);

   always_comb begin
      if (pend_valid && outranks)
         path = EXR_TAIL;
      else if (stk_valid)
         path = EXR_STACKED;
      else
         path = EXR_THREAD;
   end

endmodule

// File: rtl/exr_frame_map.sv
module exr_frame_map
   import exr_pkg::*;
#(
   parameter int FRAME_WORDS = 8,
   parameter int IDX_W       = 5,
   parameter int ADDR_W      = 32,
   parameter int WORD_BYTES  = 4,
   localparam int SLOT_W     = $clog2(FRAME_WORDS)
) (
   input  logic [SLOT_W-1:0] slot,
   output logic [IDX_W-1:0]  reg_idx,
   output logic [ADDR_W-1:0] byte_off
);

   logic [IDX_W-1:0]  idx_tab [FRAME_WORDS];
   logic [ADDR_W-1:0] off_tab [FRAME_WORDS];

   for (genvar g = 0; g < FRAME_WORDS; g++) begin : g_slot
      assign idx_tab[g] = IDX_W'(exr_slot_reg(g));
      assign off_tab[g] = ADDR_W'(g * WORD_BYTES);
   end

   assign reg_idx  = idx_tab[slot];
   assign byte_off = off_tab[slot];

endmodule

// File: rtl/exr_pop_ctl.sv
module exr_pop_ctl #(
   parameter int FRAME_WORDS = 8,
   localparam int SLOT_W     = $clog2(FRAME_WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              rd_err,
   output logic              running,
   output logic [SLOT_W-1:0] slot,
   output logic              fin,
   output logic              abort
);

   localparam logic [SLOT_W-1:0] LAST = SLOT_W'(FRAME_WORDS - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running <= 1'b0;
         slot    <= '0;
      end else if (start && !running) begin
         running <= 1'b1;
         slot    <= '0;
      end else if (running) begin
         if (rd_err || slot == LAST)
            running <= 1'b0;
         else
            slot <= slot + 1'b1;
      end
   end

   assign fin   = running && !rd_err && (slot == LAST);
   assign abort = running && rd_err;

   // R10
   err_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> !running);

   // R5
   slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      running |-> slot <= LAST);

endmodule

// File: rtl/exc_return_seq.sv
module exc_return_seq
   import exr_pkg::*;
#(
   parameter int PRIO_W      = 3,
   parameter int NUM_W       = 9,
   parameter int ADDR_W      = 32,
   parameter int DATA_W      = 32,
   parameter int FRAME_WORDS = 8,
   parameter int IDX_W       = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ret_req,
   input  logic              ret_thread,
   input  logic              ret_psp,
   input  logic              pend_valid,
   input  logic [PRIO_W-1:0] pend_prio,
   input  logic [NUM_W-1:0]  pend_num,
   input  logic              stk_valid,
   input  logic [PRIO_W-1:0] stk_prio,
   input  logic [ADDR_W-1:0] msp_in,
   input  logic [ADDR_W-1:0] psp_in,
   output logic              rd_req,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic [DATA_W-1:0] rd_data,
   input  logic              rd_err,
   output logic              rf_we,
   output logic [IDX_W-1:0]  rf_idx,
   output logic [DATA_W-1:0] rf_wdata,
   output logic              sp_wr_en,
   output logic              sp_wr_sel,
   output logic [ADDR_W-1:0] sp_wr_val,
   output logic              busy,
   output logic              done,
   output logic              fault,
   output logic [1:0]        outcome,
   output logic [NUM_W-1:0]  active_num,
   output logic              cur_handler,
   output logic              sp_sel
);

   localparam int SLOT_W      = $clog2(FRAME_WORDS);
   localparam int WORD_BYTES  = DATA_W / 8;
   localparam int FRAME_BYTES = FRAME_WORDS * WORD_BYTES;

   if (FRAME_WORDS != 8) begin : g_bad_frame
      $error("exc_return_seq: the frame layout needs FRAME_WORDS == 8");
   end
   if (DATA_W % 8 != 0) begin : g_bad_data
      $error("exc_return_seq: DATA_W must be a whole number of bytes");
   end
   if (NUM_W > DATA_W) begin : g_bad_num
      $error("exc_return_seq: NUM_W must not exceed DATA_W");
   end
   if (IDX_W < 5) begin : g_bad_idx
      $error("exc_return_seq: IDX_W must reach index 16");
   end
   if (PRIO_W < 1) begin : g_bad_prio
      $error("exc_return_seq: PRIO_W must be at least 1");
   end

   exr_outcome_e      path;
   logic              running;
   logic [SLOT_W-1:0] slot;
   logic              fin;
   logic              abort;
   logic              accept;
   logic              start;
   logic              sel_now;
   logic [ADDR_W-1:0] byte_off;

   exr_outcome_e      path_q;
   exr_outcome_e      outcome_q;
   logic [ADDR_W-1:0] base_q;
   logic              sel_q;
   logic              thr_q;
   logic              done_q;
   logic              fault_q;
   logic              spw_en_q;
   logic              spw_sel_q;
   logic [ADDR_W-1:0] spw_val_q;
   logic [NUM_W-1:0]  active_q;
   logic              sp_sel_q;

   exr_decide #(.PRIO_W(PRIO_W)) u_decide (
      .pend_valid (pend_valid),
      .pend_prio  (pend_prio),
      .stk_valid  (stk_valid),
      .stk_prio   (stk_prio),
      .path       (path)
   );

   exr_pop_ctl #(.FRAME_WORDS(FRAME_WORDS)) u_pop (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .rd_err  (rd_err),
      .running (running),
      .slot    (slot),
      .fin     (fin),
      .abort   (abort)
   );

   exr_frame_map #(
      .FRAME_WORDS (FRAME_WORDS),
      .IDX_W       (IDX_W),
      .ADDR_W      (ADDR_W),
      .WORD_BYTES  (WORD_BYTES)
   ) u_map (
      .slot     (slot),
      .reg_idx  (rf_idx),
      .byte_off (byte_off)
   );

   assign accept  = ret_req && !running;
   assign start   = accept && (path != EXR_TAIL);
   assign sel_now = ret_thread && ret_psp;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         path_q    <= EXR_THREAD;
         outcome_q <= EXR_THREAD;
         base_q    <= '0;
         sel_q     <= 1'b0;
         thr_q     <= 1'b0;
         done_q    <= 1'b0;
         fault_q   <= 1'b0;
         spw_en_q  <= 1'b0;
         spw_sel_q <= 1'b0;
         spw_val_q <= '0;
         active_q  <= '0;
         sp_sel_q  <= 1'b0;
      end else begin
         done_q   <= 1'b0;
         fault_q  <= 1'b0;
         spw_en_q <= 1'b0;
         if (accept) begin
            path_q <= path;
            thr_q  <= ret_thread;
            sel_q  <= sel_now;
            base_q <= sel_now ? psp_in : msp_in;
            if (path == EXR_TAIL) begin
               done_q    <= 1'b1;
               outcome_q <= EXR_TAIL;
               active_q  <= pend_num;
            end
         end
         if (fin) begin
            done_q    <= 1'b1;
            outcome_q <= path_q;
            active_q  <= rd_data[NUM_W-1:0];
            spw_en_q  <= 1'b1;
            spw_sel_q <= sel_q;
            spw_val_q <= base_q + ADDR_W'(FRAME_BYTES);
            sp_sel_q  <= sel_q;
         end
         if (abort)
            fault_q <= 1'b1;
      end
   end

   assign rd_req      = running;
   assign rd_addr     = base_q + byte_off;
   assign rf_we       = running && !rd_err;
   assign rf_wdata    = rd_data;
   assign sp_wr_en    = spw_en_q;
   assign sp_wr_sel   = spw_sel_q;
   assign sp_wr_val   = spw_val_q;
   assign busy        = running;
   assign done        = done_q;
   assign fault       = fault_q;
   assign outcome     = outcome_q;
   assign active_num  = active_q;
   assign cur_handler = (active_q != '0);
   assign sp_sel      = sp_sel_q;

   // R5
   addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && $past(rd_req)) |-> rd_addr == $past(rd_addr) + ADDR_W'(WORD_BYTES));

   // R1
   tail_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && outcome == 2'd2) |-> !$past(rd_req));

   // R6
   spw_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sp_wr_en |-> (done && outcome != 2'd2));

   // R8
   handler_main_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sp_wr_en && !thr_q) |-> !sp_wr_sel);

   // R4
   tie_stacked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && pend_valid && stk_valid && pend_prio == stk_prio) |=> path_q == EXR_STACKED);

   // R10
   done_fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && fault));

   // R9
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && ret_req) |=> $stable(path_q));

   // R2
   outcome_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> outcome != 2'd3);

endmodule

// File: tb/tb_exc_return_seq.sv
module tb_exc_return_seq;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ret_req = 1'b0, ret_thread = 1'b0, ret_psp = 1'b0;
   logic        pend_valid = 1'b0, stk_valid = 1'b0;
   logic [2:0]  pend_prio = '0, stk_prio = '0;
   logic [8:0]  pend_num = '0;
   logic [31:0] msp_in = '0, psp_in = '0;
   logic        rd_req, rd_err;
   logic [31:0] rd_addr, rd_data;
   logic        rf_we;
   logic [4:0]  rf_idx;
   logic [31:0] rf_wdata;
   logic        sp_wr_en, sp_wr_sel;
   logic [31:0] sp_wr_val;
   logic        busy, done, fault, cur_handler, sp_sel;
   logic [1:0]  outcome;
   logic [8:0]  active_num;

   // memory model controls
   logic [31:0] xpsr_addr = '0, xpsr_val = '0, err_addr = '0;
   logic        err_en = 1'b0;

   int n_chk = 0, n_fail = 0;
   bit finished = 0;

   // per-run observations
   int          lat, n_rf, n_rd, n_done, n_fault, n_spw;
   logic [4:0]  log_idx [8];
   logic [31:0] log_dat [8];
   logic [1:0]  s_outcome;
   logic [31:0] s_spw_val;
   logic        s_spw_sel;

   always #10 clk = ~clk;

   function automatic logic [31:0] pat(input logic [31:0] a);
      return {a[15:0] ^ 16'h5A3C, ~a[15:0]};
   endfunction

   function automatic logic [4:0] exp_idx(input int k);
      case (k)
         4: return 5'd12;
         5: return 5'd14;
         6: return 5'd15;
         7: return 5'd16;
         default: return 5'(k);
      endcase
   endfunction

   assign rd_data = (rd_addr == xpsr_addr) ? xpsr_val : pat(rd_addr);
   assign rd_err  = err_en && rd_req && (rd_addr == err_addr);

   exc_return_seq dut (
      .clk(clk), .rst_n(rst_n), .ret_req(ret_req), .ret_thread(ret_thread),
      .ret_psp(ret_psp), .pend_valid(pend_valid), .pend_prio(pend_prio),
      .pend_num(pend_num), .stk_valid(stk_valid), .stk_prio(stk_prio),
      .msp_in(msp_in), .psp_in(psp_in), .rd_req(rd_req), .rd_addr(rd_addr),
      .rd_data(rd_data), .rd_err(rd_err), .rf_we(rf_we), .rf_idx(rf_idx),
      .rf_wdata(rf_wdata), .sp_wr_en(sp_wr_en), .sp_wr_sel(sp_wr_sel),
      .sp_wr_val(sp_wr_val), .busy(busy), .done(done), .fault(fault),
      .outcome(outcome), .active_num(active_num), .cur_handler(cur_handler),
      .sp_sel(sp_sel)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // One exit: request at a negedge, then observe until done or fault.
   // inject_at > 0 raises a second (tail-chain shaped) request in that cycle.
   task automatic do_exit(input logic pv, input logic [2:0] pp, input logic [8:0] pn,
                          input logic sv, input logic [2:0] spr, input logic thr,
                          input logic psf, input int inject_at);
      @(negedge clk);
      pend_valid = pv; pend_prio = pp; pend_num = pn;
      stk_valid = sv; stk_prio = spr; ret_thread = thr; ret_psp = psf;
      xpsr_addr = ((thr && psf) ? psp_in : msp_in) + 32'd28;
      ret_req = 1'b1;
      lat = 0; n_rf = 0; n_rd = 0; n_done = 0; n_fault = 0; n_spw = 0;
      s_outcome = 2'd3; s_spw_val = '0; s_spw_sel = 1'b0;
      for (int c = 1; c <= 20; c++) begin
         @(negedge clk);
         ret_req = 1'b0;
         if (inject_at != 0 && c == inject_at) begin
            pend_valid = 1'b1; pend_prio = 3'd0; stk_valid = 1'b0;
            ret_req = 1'b1;
         end
         if (rd_req) n_rd++;
         if (rf_we) begin
            if (n_rf < 8) begin
               log_idx[n_rf] = rf_idx;
               log_dat[n_rf] = rf_wdata;
            end
            n_rf++;
         end
         if (sp_wr_en) begin
            n_spw++; s_spw_val = sp_wr_val; s_spw_sel = sp_wr_sel;
         end
         if (done || fault) begin
            lat = c;
            if (done) begin n_done++; s_outcome = outcome; end
            if (fault) n_fault++;
            break;
         end
      end
      ret_req = 1'b0;
   endtask

   task automatic check_pop(input logic [1:0] exp_out, input string tag,
                            input logic [31:0] base, input logic sel);
      chk(n_done == 1 && s_outcome == exp_out, tag, "outcome", 32'(s_outcome), 32'(exp_out));
      chk(lat == 9, "R6", "unwind latency", 32'(lat), 32'd9);
      chk(n_rf == 8, "R5", "register writes", 32'(n_rf), 32'd8);
      for (int k = 0; k < 8; k++) begin
         chk(log_idx[k] == exp_idx(k), "R5", "rf index", 32'(log_idx[k]), 32'(exp_idx(k)));
         chk(log_dat[k] == ((k == 7) ? xpsr_val : pat(base + 32'(4 * k))), "R5",
             "rf data", log_dat[k], (k == 7) ? xpsr_val : pat(base + 32'(4 * k)));
      end
      chk(n_spw == 1 && s_spw_val == base + 32'd32, "R6", "sp write value", s_spw_val, base + 32'd32);
      chk(s_spw_sel == sel && sp_sel == sel, "R8", "sp select", 32'(s_spw_sel), 32'(sel));
      chk(active_num == xpsr_val[8:0], "R7", "active number", 32'(active_num), 32'(xpsr_val[8:0]));
      chk(cur_handler == (xpsr_val[8:0] != 0), "R7", "handler flag", 32'(cur_handler),
          32'(xpsr_val[8:0] != 0));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      int idx;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      chk({done, fault, busy, rd_req, rf_we, sp_wr_en, sp_sel} == 7'b0, "R11",
          "control outputs", 32'({done, fault, busy, rd_req, rf_we, sp_wr_en, sp_sel}), 32'd0);
      chk(outcome == 2'd0 && active_num == 9'd0, "R11", "outcome/active",
          32'({outcome, active_num}), 32'd0);

      // exhaustive decision sweep
      idx = 0;
      for (int pv = 0; pv < 2; pv++)
         for (int sv = 0; sv < 2; sv++)
            for (int pp = 0; pp < 8; pp++)
               for (int sp = 0; sp < 8; sp++) begin
                  logic thr, psf, sel, tail;
                  logic [1:0] eo;
                  logic [31:0] base;
                  logic [8:0] pn;
                  string tag;
                  thr = idx[1]; psf = idx[2]; sel = thr & psf;
                  msp_in = 32'h2000_0400 + 32'(idx * 64);
                  psp_in = 32'h2000_C000 + 32'(idx * 128);
                  xpsr_val = 32'h0100_0000 | 32'((idx * 37) & 9'h1FF);
                  pn = 9'((idx * 11 + 5) & 9'h1FF);
                  base = sel ? psp_in : msp_in;
                  tail = (pv == 1) && (sv == 0 || pp < sp);
                  eo = tail ? 2'd2 : (sv == 1) ? 2'd1 : 2'd0;
                  if (tail) tag = "R1";
                  else if (pv == 1 && sv == 1 && pp == sp) tag = "R4";
                  else if (sv == 1) tag = "R2";
                  else tag = "R3";
                  do_exit(1'(pv), 3'(pp), pn, 1'(sv), 3'(sp), thr, psf, 0);
                  if (tail) begin
                     chk(n_done == 1 && s_outcome == 2'd2, "R1", "tail outcome",
                         32'(s_outcome), 32'd2);
                     chk(lat == 1, "R1", "tail latency", 32'(lat), 32'd1);
                     chk(n_rd == 0 && n_spw == 0, "R1", "tail memory/sp activity",
                         32'(n_rd + n_spw), 32'd0);
                     chk(active_num == pn, "R1", "tail active number", 32'(active_num), 32'(pn));
                  end else begin
                     check_pop(eo, tag, base, sel);
                  end
                  idx++;
               end

      // R7 zero status number returns to thread-level state
      msp_in = 32'h2000_2000; psp_in = 32'h2000_9000;
      xpsr_val = 32'h0100_0000;
      do_exit(1'b0, 3'd0, 9'd0, 1'b0, 3'd0, 1'b1, 1'b1, 0);
      check_pop(2'd0, "R3", psp_in, 1'b1);
      chk(cur_handler == 1'b0, "R7", "zero number thread", 32'(cur_handler), 32'd0);

      // R8 handler target ignores the process flag
      xpsr_val = 32'h0100_0023;
      do_exit(1'b0, 3'd0, 9'd0, 1'b1, 3'd4, 1'b0, 1'b1, 0);
      check_pop(2'd1, "R2", msp_in, 1'b0);

      // R9 request while busy is ignored
      msp_in = 32'h2000_3000;
      xpsr_val = 32'h0100_0041;
      do_exit(1'b0, 3'd0, 9'd7, 1'b1, 3'd2, 1'b0, 1'b0, 3);
      check_pop(2'd1, "R9", msp_in, 1'b0);
      begin
         int extra;
         extra = 0;
         for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            if (done || rd_req || fault) extra++;
         end
         chk(extra == 0, "R9", "activity after ignored request", 32'(extra), 32'd0);
      end

      // R10 read error mid-frame
      begin
         logic [8:0] prev_act;
         prev_act = active_num;
         msp_in = 32'h2000_5000;
         err_addr = 32'h2000_500C; err_en = 1'b1;
         do_exit(1'b0, 3'd0, 9'd0, 1'b1, 3'd3, 1'b0, 1'b0, 0);
         err_en = 1'b0;
         chk(n_fault == 1 && n_done == 0, "R10", "fault instead of done",
             32'({n_fault[15:0], n_done[15:0]}), 32'h0001_0000);
         chk(lat == 5, "R10", "fault latency", 32'(lat), 32'd5);
         chk(n_rf == 3, "R10", "writes before error", 32'(n_rf), 32'd3);
         chk(n_spw == 0, "R10", "no sp write", 32'(n_spw), 32'd0);
         chk(active_num == prev_act, "R10", "active unchanged", 32'(active_num), 32'(prev_act));
         @(negedge clk);
         chk(fault == 1'b0 && busy == 1'b0, "R10", "fault pulse ends", 32'({fault, busy}), 32'd0);
      end

      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule